// File: doc/BRIEF.md
# Processor Bus Cycle Controller

This block turns single bus-cycle requests from a processor core into the control and status signalling of a small parallel bus. The core presents a cycle type, an address and, for writes, a data byte, and holds the request until a one-cycle completion pulse comes back with the read data. On the bus side the controller runs each cycle through an address phase, a strobe phase that may be stretched by a slow device pulling READY low, and a completion phase. Throughout the cycle it drives a three-bit status code made up of an IO/memory select line and two status bits.

An external bus master can take over the bus with a HOLD request. The controller finishes any cycle in progress, raises HLDA and withdraws its output enables for address, data, read strobe, write strobe and IO/memory select. When HOLD falls it drops HLDA and resumes. A request that arrives while the bus is granted away waits until HLDA has fallen.

All tri-state lines are modelled as a value plus an active-high output enable, so the pads can be built outside the block.

Top module: `buscyc_ctrl`

## Requirements
- R1: After reset the bus is idle: all output enables and HLDA are low, rd_n and wr_n are high, s1 and s0 are 0 and rsp_done is low.
- R2: During a cycle, {iom,s1,s0} follows req_type: 0 fetch = 011, 1 memory read = 001, 2 memory write = 010, 3 I/O read = 101, 4 I/O write = 110, 5 interrupt acknowledge = 111. Codes 6 and 7 run as a memory read (001).
- R3: When no cycle runs (idle or granted away), s1 and s0 are 0 and iom_oe is low, which is the halt code with IO/M floating.
- R4: A request accepted at a clock edge gives one cycle of address phase (bus_oe high, address valid, both strobes high), then the strobe goes low for the strobe phase and stays low through the completion phase; rsp_done is high for exactly the one cycle after the completion phase.
- R5: Each clock edge in the strobe or wait phase at which ready is low adds one wait cycle, with the strobe, status and address held unchanged.
- R6: For read types, bus_din is captured at the edge ending the completion phase and shown on rsp_rdata with rsp_done; rsp_rdata keeps that value through later write cycles.
- R7: rd_n and wr_n are never low together; read types (0, 1, 3, 5, 6, 7) pulse only rd_n and write types (2, 4) only wr_n, and bus_dout_oe is high only in the strobe, wait and completion phases of write cycles.
- R8: A high hold is granted only when no cycle is running; HLDA rises one cycle after hold is sampled high in idle, and a hold raised mid-cycle waits until that cycle's rsp_done.
- R9: While hlda is high, bus_oe, iom_oe and bus_dout_oe are low and both strobes are high.
- R10: hlda falls one cycle after hold is sampled low; a request that waited during the grant starts its address phase in the cycle after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Core request, held until rsp_done |
| req_type | input | 3 | Cycle type code |
| req_addr | input | ADDR_W | Cycle address |
| req_wdata | input | DATA_W | Write data |
| rsp_rdata | output | DATA_W | Last read data |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_addr | output | ADDR_W | Address bus value |
| bus_oe | output | 1 | Enable for address bus, rd_n and wr_n |
| bus_dout | output | DATA_W | Data bus value driven on writes |
| bus_dout_oe | output | 1 | Data bus output enable |
| bus_din | input | DATA_W | Data bus value read back |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| iom | output | 1 | IO (1) or memory (0) select |
| iom_oe | output | 1 | Enable for iom |
| s1 | output | 1 | Status bit 1 |
| s0 | output | 1 | Status bit 0 |
| ready | input | 1 | Device ready; low inserts wait cycles |
| hold | input | 1 | External bus request |
| hlda | output | 1 | Bus grant acknowledge |

## Verification
A wrong phase in the sequencer shows at the ports within one clock: a strobe that falls in the address phase, a missing or doubled wait cycle, or an rsp_done that arrives one cycle early or late is visible on rd_n, wr_n and rsp_done in the cycle where it happens. A wrongly latched cycle type corrupts {iom,s1,s0} from the first address-phase cycle, and a grant taken mid-cycle shows as HLDA rising while a strobe is still low. Read data captured at the wrong edge surfaces only with the next rsp_done, so reads are run with a bus_din value that changes at the completion phase.

// File: rtl/buscyc_pkg.sv
package buscyc_pkg;

  localparam int CYC_W = 3;

  localparam logic [CYC_W-1:0] CYC_FETCH = 3'd0;
  localparam logic [CYC_W-1:0] CYC_MRD   = 3'd1;
  localparam logic [CYC_W-1:0] CYC_MWR   = 3'd2;
  localparam logic [CYC_W-1:0] CYC_IORD  = 3'd3;
  localparam logic [CYC_W-1:0] CYC_IOWR  = 3'd4;
  localparam logic [CYC_W-1:0] CYC_INTA  = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_T1   = 3'd1,
    ST_T2   = 3'd2,
    ST_TW   = 3'd3,
    ST_T3   = 3'd4,
    ST_HELD = 3'd5
  } bst_e;

  typedef struct packed {
    logic iom;
    logic s1;
    logic s0;
  } stat_t;

endpackage

// File: rtl/buscyc_status_enc.sv
module buscyc_status_enc
  import buscyc_pkg::*;
(
  input  logic [CYC_W-1:0] cyc_type,
  output stat_t            stat,
  output logic             is_write
);

  always_comb begin
    is_write = 1'b0;
    case (cyc_type)
      CYC_FETCH: stat = '{iom: 1'b0, s1: 1'b1, s0: 1'b1};
      CYC_MRD:   stat = '{iom: 1'b0, s1: 1'b0, s0: 1'b1};
      CYC_MWR: begin
        stat     = '{iom: 1'b0, s1: 1'b1, s0: 1'b0};
        is_write = 1'b1;
      end
      CYC_IORD:  stat = '{iom: 1'b1, s1: 1'b0, s0: 1'b1};
      CYC_IOWR: begin
        stat     = '{iom: 1'b1, s1: 1'b1, s0: 1'b0};
        is_write = 1'b1;
      end
      CYC_INTA:  stat = '{iom: 1'b1, s1: 1'b1, s0: 1'b1};
      default:   stat = '{iom: 1'b0, s1: 1'b0, s0: 1'b1};
    endcase
  end

endmodule

// File: rtl/buscyc_seq.sv
module buscyc_seq
  import buscyc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  input  logic hold,
  input  logic ready,
  output bst_e state,
  output bst_e state_nx,
  output logic accept
);

  // hold outranks a waiting request, and is looked at only between cycles
  assign accept = (state == ST_IDLE) && !hold && req_valid;

  always_comb begin
    state_nx = state;
    case (state)
      ST_IDLE: begin
        if (hold)           state_nx = ST_HELD;
        else if (req_valid) state_nx = ST_T1;
      end
      ST_T1:   state_nx = ST_T2;
      ST_T2,
      ST_TW:   state_nx = ready ? ST_T3 : ST_TW;
      ST_T3:   state_nx = ST_IDLE;
      ST_HELD: state_nx = hold ? ST_HELD : ST_IDLE;
      default: state_nx = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_IDLE;
    else     state <= state_nx;
  end

  // R5
  wait_extend_chk: assert property (@(posedge clk) disable iff (rst)
    ((state == ST_T2 || state == ST_TW) && !ready) |=> (state == ST_TW));

  // R8
  hold_mid_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_T1 || state == ST_T2 || state == ST_TW || state == ST_T3)
      |=> (state != ST_HELD));

endmodule

// File: rtl/buscyc_ctrl.sv
module buscyc_ctrl
  import buscyc_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [CYC_W-1:0]  req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_done,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_oe,
  output logic [DATA_W-1:0] bus_dout,
  output logic              bus_dout_oe,
  input  logic [DATA_W-1:0] bus_din,
  output logic              rd_n,
  output logic              wr_n,
  output logic              iom,
  output logic              iom_oe,
  output logic              s1,
  output logic              s0,
  input  logic              ready,
  input  logic              hold,
  output logic              hlda
);

  bst_e state, state_nx;
  logic accept;

  logic [CYC_W-1:0]  lat_type;
  logic [ADDR_W-1:0] lat_addr;
  logic [DATA_W-1:0] lat_wdata;

  logic [CYC_W-1:0]  type_nx;
  logic [ADDR_W-1:0] addr_nx;
  logic [DATA_W-1:0] wdata_nx;
  stat_t             stat_nx;
  logic              wr_nx;
  logic              in_cyc_nx;
  logic              strobe_nx;

  buscyc_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .hold      (hold),
    .ready     (ready),
    .state     (state),
    .state_nx  (state_nx),
    .accept    (accept)
  );

  // cycle attributes as they will be after this edge
  assign type_nx  = accept ? req_type  : lat_type;
  assign addr_nx  = accept ? req_addr  : lat_addr;
  assign wdata_nx = accept ? req_wdata : lat_wdata;

  buscyc_status_enc u_enc (
    .cyc_type (type_nx),
    .stat     (stat_nx),
    .is_write (wr_nx)
  );

  assign in_cyc_nx = (state_nx == ST_T1) || (state_nx == ST_T2) ||
                     (state_nx == ST_TW) || (state_nx == ST_T3);
  assign strobe_nx = (state_nx == ST_T2) || (state_nx == ST_TW) ||
                     (state_nx == ST_T3);

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_type    <= CYC_MRD;
      lat_addr    <= '0;
      lat_wdata   <= '0;
      rsp_rdata   <= '0;
      rsp_done    <= 1'b0;
      bus_addr    <= '0;
      bus_oe      <= 1'b0;
      bus_dout    <= '0;
      bus_dout_oe <= 1'b0;
      rd_n        <= 1'b1;
      wr_n        <= 1'b1;
      iom         <= 1'b0;
      iom_oe      <= 1'b0;
      s1          <= 1'b0;
      s0          <= 1'b0;
      hlda        <= 1'b0;
    end else begin
      if (accept) begin
        lat_type  <= req_type;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end
      bus_oe      <= in_cyc_nx;
      iom_oe      <= in_cyc_nx;
      bus_addr    <= in_cyc_nx ? addr_nx : '0;
      iom         <= in_cyc_nx & stat_nx.iom;
      s1          <= in_cyc_nx & stat_nx.s1;
      s0          <= in_cyc_nx & stat_nx.s0;
      rd_n        <= !(strobe_nx && !wr_nx);
      wr_n        <= !(strobe_nx && wr_nx);
      bus_dout_oe <= strobe_nx && wr_nx;
      bus_dout    <= wdata_nx;
      hlda        <= (state_nx == ST_HELD);
      rsp_done    <= (state == ST_T3);
      if (state == ST_T3 && !wr_nx) rsp_rdata <= bus_din;
    end
  end

  // R7
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  // R9
  held_float_chk: assert property (@(posedge clk) disable iff (rst)
    hlda |-> (!bus_oe && !iom_oe && !bus_dout_oe && rd_n && wr_n));

  // R10
  hlda_release_chk: assert property (@(posedge clk) disable iff (rst)
    (hlda && !hold) |=> !hlda);

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R3
  idle_halt_code_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> (!s1 && !s0 && !iom_oe));

endmodule

// File: tb/test_buscyc_ctrl.sv
module test_buscyc_ctrl;

  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [2:0]    req_type;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_done;
  logic [AW-1:0] bus_addr;
  logic          bus_oe;
  logic [DW-1:0] bus_dout;
  logic          bus_dout_oe;
  logic [DW-1:0] bus_din;
  logic          rd_n, wr_n, iom, iom_oe, s1, s0;
  logic          ready, hold, hlda;

  int n_tests = 0;
  int n_fail  = 0;
  logic [DW-1:0] last_rd = '0;

  always #5 clk = ~clk;

  buscyc_ctrl #(.ADDR_W(AW), .DATA_W(DW)) i_buscyc_ctrl (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_type(req_type),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_rdata(rsp_rdata),
    .rsp_done(rsp_done), .bus_addr(bus_addr), .bus_oe(bus_oe),
    .bus_dout(bus_dout), .bus_dout_oe(bus_dout_oe), .bus_din(bus_din),
    .rd_n(rd_n), .wr_n(wr_n), .iom(iom), .iom_oe(iom_oe), .s1(s1), .s0(s0),
    .ready(ready), .hold(hold), .hlda(hlda)
  );

  function automatic logic [2:0] exp_stat(input logic [2:0] t);
    case (t)
      3'd0: return 3'b011;
      3'd1: return 3'b001;
      3'd2: return 3'b010;
      3'd3: return 3'b101;
      3'd4: return 3'b110;
      3'd5: return 3'b111;
      default: return 3'b001;
    endcase
  endfunction

  function automatic logic exp_wr(input logic [2:0] t);
    return (t == 3'd2) || (t == 3'd4);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_cycle(input logic [2:0] t, input logic [AW-1:0] a,
                          input logic [DW-1:0] wd, input logic [DW-1:0] din,
                          input int waits);
    logic wr;
    wr = exp_wr(t);
    @(negedge clk);
    req_valid = 1'b1; req_type = t; req_addr = a; req_wdata = wd;
    ready = (waits == 0);
    @(negedge clk);
    chk("R2 status code", {29'd0, iom, s1, s0}, {29'd0, exp_stat(t)});
    chk("R4 address phase addr", {16'd0, bus_addr}, {16'd0, a});
    chk("R4 address phase strobes high", {30'd0, rd_n, wr_n}, 32'd3);
    chk("R4 address phase enables", {30'd0, bus_oe, iom_oe}, 32'd3);
    req_valid = 1'b0;
    @(negedge clk);
    chk("R7 strobe select", {30'd0, rd_n, wr_n}, wr ? 32'd2 : 32'd1);
    chk("R7 dout_oe", {31'd0, bus_dout_oe}, {31'd0, wr});
    if (wr) chk("R7 write data", {24'd0, bus_dout}, {24'd0, wd});
    for (int k = 0; k < waits; k++) begin
      @(negedge clk);
      chk("R5 wait strobe held", {30'd0, rd_n, wr_n}, wr ? 32'd2 : 32'd1);
      chk("R5 wait addr stable", {16'd0, bus_addr}, {16'd0, a});
      chk("R5 wait status stable", {29'd0, iom, s1, s0}, {29'd0, exp_stat(t)});
      if (k == waits - 1) ready = 1'b1;
    end
    @(negedge clk);
    chk("R4 completion strobe", {30'd0, rd_n, wr_n}, wr ? 32'd2 : 32'd1);
    chk("R4 no early done", {31'd0, rsp_done}, 32'd0);
    bus_din = din;
    @(negedge clk);
    chk("R4 done pulse", {31'd0, rsp_done}, 32'd1);
    chk("R3 idle halt code", {26'd0, bus_oe, iom_oe, s1, s0, rd_n, wr_n}, 32'b000011);
    chk("R7 dout_oe off", {31'd0, bus_dout_oe}, 32'd0);
    if (!wr) last_rd = din;
    chk("R6 read data", {24'd0, rsp_rdata}, {24'd0, last_rd});
    bus_din = ~din;
    @(negedge clk);
    chk("R4 done one cycle", {31'd0, rsp_done}, 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    rst = 1'b1; req_valid = 1'b0; req_type = '0; req_addr = '0; req_wdata = '0;
    bus_din = '0; ready = 1'b1; hold = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset enables", {29'd0, bus_oe, iom_oe, bus_dout_oe}, 32'd0);
    chk("R1 reset strobes", {30'd0, rd_n, wr_n}, 32'd3);
    chk("R1 reset status/hlda/done", {28'd0, s1, s0, hlda, rsp_done}, 32'd0);

    // R2 every code, directed, plus R6 across writes
    for (int t = 0; t < 8; t++)
      do_cycle(t[2:0], 16'h1000 + 16'(t), 8'hA0 + 8'(t), 8'h50 + 8'(t), 0);
    // R5 several wait lengths
    do_cycle(3'd1, 16'hBEEF, 8'h00, 8'h3C, 1);
    do_cycle(3'd4, 16'h00FF, 8'h77, 8'h11, 3);
    do_cycle(3'd3, 16'hFFFF, 8'h00, 8'hC3, 5);

    // R8 hold in idle granted next cycle
    @(negedge clk); hold = 1'b1;
    @(negedge clk);
    chk("R8 grant from idle", {31'd0, hlda}, 32'd1);
    chk("R9 floated while held", {29'd0, bus_oe, iom_oe, bus_dout_oe}, 32'd0);
    chk("R9 strobes inactive", {30'd0, rd_n, wr_n}, 32'd3);
    // R10 request waits during grant
    req_valid = 1'b1; req_type = 3'd0; req_addr = 16'h2222;
    repeat (3) begin
      @(negedge clk);
      chk("R10 request blocked while held", {30'd0, hlda, bus_oe}, 32'd2);
    end
    hold = 1'b0;
    @(negedge clk);
    chk("R10 hlda drops", {30'd0, hlda, bus_oe}, 32'd0);
    @(negedge clk);
    chk("R10 waiting request starts", {31'd0, bus_oe}, 32'd1);
    chk("R2 status after grant", {29'd0, iom, s1, s0}, 32'b011);
    req_valid = 1'b0;
    @(negedge clk); @(negedge clk); @(negedge clk);
    chk("R4 done after grant", {31'd0, rsp_done}, 32'd1);

    // R8 hold raised mid-cycle waits for completion
    @(negedge clk);
    req_valid = 1'b1; req_type = 3'd2; req_addr = 16'h0400; req_wdata = 8'h99; ready = 1'b0;
    @(negedge clk);
    req_valid = 1'b0; hold = 1'b1;
    @(negedge clk);
    chk("R8 no grant in strobe phase", {31'd0, hlda}, 32'd0);
    @(negedge clk);
    chk("R8 no grant in wait", {30'd0, hlda, wr_n}, 32'd0);
    ready = 1'b1;
    @(negedge clk);
    chk("R8 no grant in completion", {31'd0, hlda}, 32'd0);
    @(negedge clk);
    chk("R8 done before grant", {30'd0, rsp_done, hlda}, 32'd2);
    @(negedge clk);
    chk("R8 grant after done", {31'd0, hlda}, 32'd1);
    chk("R9 floated after grant", {29'd0, bus_oe, iom_oe, bus_dout_oe}, 32'd0);
    hold = 1'b0;
    @(negedge clk);
    chk("R10 release", {31'd0, hlda}, 32'd0);

    // random mix
    for (int i = 0; i < 60; i++) begin
      logic [2:0] t;
      t = 3'($urandom_range(0, 7));
      do_cycle(t, 16'($urandom), 8'($urandom), 8'($urandom), int'($urandom_range(0, 3)));
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule